// File: doc/BRIEF.md
# Two-Wire Serial Control Register Slave

This block connects a two-wire serial bus host to a bank of control registers that sit beside a video processing datapath. The host addresses the block with a fixed 7-bit device address. In a write transaction, the first data byte loads an internal register pointer. Every byte after that is stored at the pointer, and the pointer then advances by one. A transaction may carry any number of bytes.

To read, the host first sets the pointer in a write transaction and closes it with STOP. It then opens a new transaction with the read form of the address. The slave then shifts bytes out starting at the pointer and advances the pointer after each byte. The host acknowledges each byte to continue and leaves the acknowledge high to finish.

The low 31 locations are writable control bytes, and all of them appear as one parallel output vector. The next six locations return live status inputs. Any location above those reads as zero. SCL and SDA are brought into the system clock domain through two flip-flop stages. The system clock must run at least eight times faster than SCL.

Top module: `ctl_i2c_slave`

## Requirements
- R1: A falling SDA while SCL is high is decoded as START. A rising SDA while SCL is high is decoded as STOP. STOP aborts any transaction in progress, including a partly received byte, and the slave releases SDA (sda_oe = 0).
- R2: The address byte 24h (write) and the address byte 25h (read) are acknowledged by driving SDA low in the ninth clock. Any other address byte gets no acknowledge, and the bytes that follow it are ignored until the next START.
- R3: In a write, the first byte after the address loads the pointer. Each later byte is stored at the pointer, and the pointer then increments by one. The slave acknowledges every data byte.
- R4: After address 25h, the slave drives bytes MSB first starting at the current pointer. The pointer increments after each byte it sends.
- R5: During a read, a master acknowledge (SDA low in the ninth clock) makes the slave send the next byte. A master not-acknowledge (SDA high) ends the read, and SDA stays released.
- R6: Locations 1Fh to 24h read the status input. Location 1Fh+k returns status_i[8k+7:8k], for k = 0 to 5.
- R7: Writes to locations 1Fh and above are acknowledged but change no register. Reads from locations 25h and above return 00h.
- R8: While rst is high, every control byte is cleared to 00h and SDA is released.
- R9: sda_oe changes from released to driving only while SCL is low.
- R10: Control location n (n = 0 to 1Eh) appears on ctrl_o[8n+7:8n].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open drain); 0 releases it |
| status_i | input | 48 | Read-only status bytes for locations 1Fh to 24h |
| ctrl_o | output | 248 | All 31 control bytes, location n at bits [8n+7:8n] |

## Verification
Storing a received byte and advancing the pointer happen in the same cycle, on the SCL fall that ends the eighth data bit. If the two were mis-sequenced, a byte would land one location off. The bench provokes this with bursts that start near 1Eh, so that the last writable byte and the first discarded byte come back to back. It then compares the whole ctrl_o vector against a model that places byte i at pointer+i. A read burst that runs from control space through status space into the unmapped range checks the same timing for read loads: each returned byte must match the location the pointer held before it advanced.

// File: rtl/ctl_i2c_pkg.sv
package ctl_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } bus_state_e;
endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] scl_sh, sda_sh;
  logic scl_q, sda_q;
  logic scl_s;

  // idle bus is high on both lines
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[TOP-1:0], scl_i};
      sda_sh <= {sda_sh[TOP-1:0], sda_i};
      scl_q  <= scl_sh[TOP];
      sda_q  <= sda_sh[TOP];
    end
  end

  assign scl_s     = scl_sh[TOP];
  assign sda_s     = sda_sh[TOP];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // R1: data edge while clock stays high
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_proto_fsm.sv
module i2c_proto_fsm
  import ctl_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h12,
  parameter int         AW       = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] ptr,
  output logic          wr_en,
  output logic [7:0]    wr_data,
  output logic          sda_oe
);
  localparam logic [3:0] LAST_BIT = 4'd8;

  bus_state_e state;
  logic [3:0] cnt;
  logic [7:0] rx_sh, tx_sh;
  logic       rw_bit, have_ptr, m_nak;

  wire byte_done = scl_fall && (cnt == LAST_BIT);

  // R3: store at current pointer on the edge that ends the eighth bit
  assign wr_en   = (state == ST_WDATA) && byte_done && have_ptr;
  assign wr_data = rx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      ptr      <= '0;
      rw_bit   <= 1'b0;
      have_ptr <= 1'b0;
      m_nak    <= 1'b1;
      sda_oe   <= 1'b0;
    end else if (start_det) begin
      state  <= ST_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_WDATA: begin
          if (scl_rise) begin
            rx_sh <= {rx_sh[6:0], sda_s};
            cnt   <= cnt + 4'd1;
          end else if (byte_done) begin
            if (state == ST_ADDR) begin
              // R2: acknowledge only the own address
              if (rx_sh[7:1] == DEV_ADDR) begin
                sda_oe <= 1'b1;
                rw_bit <= rx_sh[0];
                state  <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              sda_oe <= 1'b1;
              state  <= ST_WACK;
              if (!have_ptr) begin
                ptr      <= rx_sh[AW-1:0];
                have_ptr <= 1'b1;
              end else begin
                ptr <= ptr + 1'b1;
              end
            end
          end
        end
        ST_ADDR_ACK, ST_RACK: begin
          if (scl_rise && state == ST_RACK) begin
            m_nak <= sda_s;
          end else if (scl_fall) begin
            cnt <= '0;
            if (state == ST_ADDR_ACK && !rw_bit) begin
              sda_oe   <= 1'b0;
              have_ptr <= 1'b0;
              state    <= ST_WDATA;
            end else if (state == ST_ADDR_ACK || !m_nak) begin
              // R4: load byte at pointer, MSB on the line first
              tx_sh  <= rd_data;
              sda_oe <= ~rd_data[7];
              ptr    <= ptr + 1'b1;
              state  <= ST_RDATA;
            end else begin
              // R5: master refused, stay off the line
              sda_oe <= 1'b0;
              state  <= ST_IDLE;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            state  <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            cnt <= cnt + 4'd1;
          end else if (byte_done) begin
            sda_oe <= 1'b0;
            state  <= ST_RACK;
          end else if (scl_fall) begin
            tx_sh  <= {tx_sh[6:0], 1'b0};
            sda_oe <= ~tx_sh[6];
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int NUM_CTRL = 31,
  parameter int NUM_STAT = 6,
  parameter int AW       = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [AW-1:0]         rd_addr,
  input  logic [NUM_STAT*8-1:0] status_i,
  output logic [NUM_CTRL*8-1:0] ctrl_o,
  output logic [7:0]            rd_data
);
  logic [7:0] ctrl_q [NUM_CTRL];

  for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
    localparam logic [AW-1:0] LOC = AW'(g);
    // R8 clear, R7 only matching writable locations update
    always_ff @(posedge clk) begin
      if (rst)                            ctrl_q[g] <= '0;
      else if (wr_en && (wr_addr == LOC)) ctrl_q[g] <= wr_data;
    end
    // R10: location n on bits [8n+7:8n]
    assign ctrl_o[8*g +: 8] = ctrl_q[g];
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_CTRL; k++)
      if (rd_addr == AW'(k)) rd_data = ctrl_q[k];
    // R6: status bytes follow the control bytes
    for (int k = 0; k < NUM_STAT; k++)
      if (rd_addr == AW'(NUM_CTRL + k)) rd_data = status_i[8*k +: 8];
  end
endmodule

// File: rtl/ctl_i2c_slave.sv
module ctl_i2c_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h12,
  parameter int         NUM_CTRL = 31,
  parameter int         NUM_STAT = 6,
  parameter int         AW       = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  input  logic [NUM_STAT*8-1:0] status_i,
  output logic [NUM_CTRL*8-1:0] ctrl_o
);
  logic          sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          wr_en;
  logic [7:0]    wr_data, rd_data;
  logic [AW-1:0] ptr;

  i2c_pin_sync #(.SYNC_STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_proto_fsm #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_fsm (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en), .wr_data(wr_data),
    .sda_oe(sda_oe)
  );

  i2c_reg_bank #(.NUM_CTRL(NUM_CTRL), .NUM_STAT(NUM_STAT), .AW(AW)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(ptr), .wr_data(wr_data),
    .rd_addr(ptr), .status_i(status_i), .ctrl_o(ctrl_o), .rd_data(rd_data)
  );
endmodule

// File: rtl/ctl_i2c_slave_chk.sv
module ctl_i2c_slave_chk #(
  parameter int NUM_CTRL = 31,
  parameter int AW       = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  scl_i,
  input logic                  stop_det,
  input logic                  sda_oe,
  input logic                  wr_en,
  input logic [AW-1:0]         wr_addr,
  input logic [7:0]            wr_data,
  input logic [NUM_CTRL*8-1:0] ctrl_o
);
  localparam logic [AW-1:0] RO_BASE = AW'(NUM_CTRL);

  logic [AW-1:0] last_addr;
  logic [7:0]    last_data;
  always_ff @(posedge clk) begin
    last_addr <= wr_addr;
    last_data <= wr_data;
  end

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe); // R1

  AST_DRIVE_WHEN_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_i); // R9

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr < RO_BASE) |=> (ctrl_o[8*int'(last_addr) +: 8] == last_data)); // R3

  AST_RO_DISCARD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr >= RO_BASE) |=> $stable(ctrl_o)); // R7

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (ctrl_o == '0 && !sda_oe)); // R8
endmodule

bind ctl_i2c_slave ctl_i2c_slave_chk #(.NUM_CTRL(NUM_CTRL), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .stop_det(stop_det), .sda_oe(sda_oe),
  .wr_en(wr_en), .wr_addr(ptr), .wr_data(wr_data), .ctrl_o(ctrl_o)
);

// File: tb/tb_ctl_i2c_slave.sv
module tb_ctl_i2c_slave;
  localparam int NC = 31;
  localparam int NS = 6;
  localparam int Q  = 10;
  localparam logic [47:0] STAT = 48'h5A_C3_0F_F0_81_3C;
  // table: {pointer, data} single-byte writes, each read back
  localparam logic [15:0] VEC [8] = '{
    {8'h00, 8'hA5}, {8'h1E, 8'h3C}, {8'h05, 8'hFF}, {8'h1F, 8'h77},
    {8'h24, 8'h11}, {8'h40, 8'h99}, {8'h10, 8'h01}, {8'h00, 8'h5A}
  };

  logic clk = 1'b0, rst = 1'b1, scl = 1'b1, m_sda = 1'b1;
  logic sda_oe;
  logic [NC*8-1:0] ctrl_o;
  wire  sda_line = sda_oe ? 1'b0 : m_sda;

  int checks = 0, fails = 0, viol = 0;
  bit finished = 0;
  logic [7:0] shadow [NC];
  logic [7:0] wbuf [12];
  logic [7:0] rbuf [12];

  always #2.5 clk = ~clk;

  ctl_i2c_slave dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .status_i(STAT), .ctrl_o(ctrl_o)
  );

  // R9 monitor: slave must not start driving while SCL is high
  logic prev_oe = 1'b0, prev_scl = 1'b1;
  always @(negedge clk) begin
    if (!rst && scl && prev_scl && sda_oe && !prev_oe) viol++;
    prev_oe  <= sda_oe;
    prev_scl <= scl;
  end

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NC*8-1:0] shadow_vec();
    logic [NC*8-1:0] v;
    for (int i = 0; i < NC; i++) v[8*i +: 8] = shadow[i];
    return v;
  endfunction

  function automatic logic [7:0] exp_rd(input int a);
    if (a < NC) return shadow[a];
    if (a < NC + NS) return STAT[8*(a-NC) +: 8];
    return 8'h00;
  endfunction

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bit_out(input logic b);
    wq(); m_sda = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    m_sda = 1'b1; wq(); wq(); scl = 1'b1; wq(); b = sda_line; wq(); scl = 1'b0;
  endtask

  task automatic do_start();
    m_sda = 1'b1; wq(); scl = 1'b1; wq(); m_sda = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic do_stop();
    wq(); m_sda = 1'b0; wq(); scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic nak;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(nak);
    ack = ~nak;
  endtask

  task automatic rbyte(input logic last, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) bit_in(d[i]);
    bit_out(last);
  endtask

  task automatic write_burst(input logic [7:0] p, input int n);
    logic ack;
    do_start();
    wbyte(8'h24, ack); chk("R2 write address ack", 256'(ack), 256'(1));
    wbyte(p, ack);     chk("R3 pointer byte ack", 256'(ack), 256'(1));
    for (int i = 0; i < n; i++) begin
      wbyte(wbuf[i], ack);
      chk("R3 data byte ack", 256'(ack), 256'(1));
      if (int'(p) + i < NC) shadow[int'(p) + i] = wbuf[i];
    end
    do_stop();
  endtask

  task automatic read_burst(input logic [7:0] p, input int n);
    logic ack;
    do_start();
    wbyte(8'h24, ack); wbyte(p, ack);
    do_stop();
    do_start();
    wbyte(8'h25, ack); chk("R2 read address ack", 256'(ack), 256'(1));
    for (int i = 0; i < n; i++) rbyte(i == n - 1, rbuf[i]);
    do_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic ack;
    for (int i = 0; i < NC; i++) shadow[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk("R8 reset ctrl_o", 256'(ctrl_o), 256'(0));
    chk("R1 idle release", 256'(sda_oe), 256'(0));

    // table walk: single write then read back (R3 R7 R10 / R4 R6 R7)
    for (int v = 0; v < 8; v++) begin
      wbuf[0] = VEC[v][7:0];
      write_burst(VEC[v][15:8], 1);
      chk("R10 ctrl_o after table write", 256'(ctrl_o), 256'(shadow_vec()));
      read_burst(VEC[v][15:8], 1);
      chk("R4 table readback", 256'(rbuf[0]), 256'(exp_rd(int'(VEC[v][15:8]))));
    end

    // R3 R7: burst across end of writable space
    for (int i = 0; i < 5; i++) wbuf[i] = 8'hC0 + 8'(i);
    write_burst(8'h1C, 5);
    chk("R7 burst across 1Eh", 256'(ctrl_o), 256'(shadow_vec()));

    // R4 R5 R6 R7: read control, status, unmapped in one burst
    read_burst(8'h1C, 10);
    for (int i = 0; i < 10; i++)
      chk("R6 burst read byte", 256'(rbuf[i]), 256'(exp_rd(28 + i)));
    chk("R5 released after nak", 256'(sda_oe), 256'(0));

    // R2: foreign address ignored
    do_start();
    wbyte(8'h30, ack); chk("R2 foreign address nak", 256'(ack), 256'(0));
    wbyte(8'h02, ack); chk("R2 foreign byte nak", 256'(ack), 256'(0));
    wbyte(8'hEE, ack);
    do_stop();
    chk("R2 foreign write no effect", 256'(ctrl_o), 256'(shadow_vec()));

    // R1: STOP after a partial pointer byte aborts
    do_start();
    wbyte(8'h24, ack);
    for (int i = 0; i < 4; i++) bit_out(1'b0);
    do_stop();
    chk("R1 abort released", 256'(sda_oe), 256'(0));
    wbuf[0] = 8'h6D;
    write_burst(8'h03, 1);
    chk("R1 write after abort", 256'(ctrl_o), 256'(shadow_vec()));

    chk("R9 no drive while scl high", 256'(viol), 256'(0));

    // R8: reset clears programmed registers
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 ctrl cleared", 256'(ctrl_o), 256'(0));
    chk("R8 sda released", 256'(sda_oe), 256'(0));
    rst = 1'b0;

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule